// File: doc/BRIEF.md
# Immediate-Operand Accumulator Processor Core

This block is a small processor core with one general-purpose register, the accumulator. Every instruction word holds its operand as an immediate field, so a single read of the memory returns both what to do and what to do it with. The core has no register file and never fetches an operand from memory.

Values that must vary at run time are kept in the operand fields of instructions. A store instruction (PUT) copies the low bits of the accumulator into the operand field of the word at a given address and leaves that word's opcode as it was. Because PUT can rewrite the operand of another PUT, a program can build indirect writes and array indexing. The core connects to one single-port synchronous memory that holds both program and data. The memory returns read data on the cycle after a read is requested. A halted output and the accumulator and program counter values show the core's status.

An instruction that is not PUT takes two cycles: fetch, then execute. PUT takes three cycles. In its execute cycle it reads the target word, and in the next cycle it writes the merged word back. Both steps finish before the next fetch.

Top module: `acc_core`

## Requirements
- R1: While rst_n is low, the accumulator, the program counter and halted are 0, and no memory read or write is issued; the reset takes effect without waiting for a clock edge. After rst_n rises, the first three falling-edge samples show no memory access, and the fourth shows a read of address 0.
- R2: An instruction word is 16 bits. The opcode is in bits [15:12] and the operand in bits [11:0]. Opcodes: 0 HALT, 1 LDI, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 XOR, 7 PUT, 8 JMP, 9 JZ. A PUT changes only bits [11:0] of its target, so the target's opcode stays the same.
- R3: Each instruction is fetched with exactly one read cycle at the address held in the program counter. The word arrives on the following cycle, when it is executed. A non-PUT instruction takes two cycles, and a read and a write are never requested in the same cycle.
- R4: LDI loads the operand, zero-extended, into the accumulator. ADD, SUB, AND, OR and XOR combine the accumulator with the zero-extended operand, modulo 2^16. The result is visible in the cycle after execute.
- R5: After every instruction other than a jump or HALT, the program counter advances by one and wraps from 0xFFF to 0.
- R6: JMP loads the program counter with the operand. JZ loads it with the operand when the accumulator is zero, and otherwise advances it by one.
- R7: PUT reads the target word, whose address is the operand, in the cycle after its fetch. In the next cycle it writes the same address with {old opcode, accumulator[11:0]}. The accumulator does not change, and the program counter advances by one.
- R8: A word rewritten by PUT is executed with its new operand, including when it is the very next instruction. A PUT whose operand was rewritten writes to the new address.
- R9: HALT raises halted from the cycle after its execute. From then until reset, no memory access occurs, and the accumulator and the program counter (which keeps the HALT's address) stay constant.
- R10: Opcodes 10 to 15 do nothing except advance the program counter by one.
- R11: Pulling rst_n low in the middle of a program clears the core at once. After release, the core restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Memory read request; data returns one cycle later |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| halted | output | 1 | Core has executed HALT |
| acc | output | 16 | Accumulator value |
| pc | output | 12 | Program counter value |

## Verification
The memory port is due in the same cycle as the state that drives it. For a fetch or a PUT this is the address and read request, and in the PUT write cycle it is the write. Accumulator and program counter results are due in the cycle after the execute cycle, and halted rises in that same cycle. After reset release, three quiet cycles come before the first fetch. The bench keeps a behavioural model that advances one step per clock, with its own copy of memory, and compares every output at each falling edge. It then checks memory contents and final register values after each program halts, and checks the outputs a nanosecond after an asynchronous reset.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_HALT = 4'h0;
  localparam logic [OP_W-1:0] OPC_LDI  = 4'h1;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'h2;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'h3;
  localparam logic [OP_W-1:0] OPC_AND  = 4'h4;
  localparam logic [OP_W-1:0] OPC_OR   = 4'h5;
  localparam logic [OP_W-1:0] OPC_XOR  = 4'h6;
  localparam logic [OP_W-1:0] OPC_PUT  = 4'h7;
  localparam logic [OP_W-1:0] OPC_JMP  = 4'h8;
  localparam logic [OP_W-1:0] OPC_JZ   = 4'h9;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } alu_op_e;

  typedef enum logic [1:0] {
    PC_STEP,
    PC_LOAD,
    PC_LOAD_IF_ZERO,
    PC_HOLD
  } pc_sel_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH,
    ST_EXEC,
    ST_WRITE,
    ST_HALT
  } state_e;

endpackage

// File: rtl/acc_core_rstsync.sv
module acc_core_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output logic            acc_we_o,
  output alu_op_e         alu_op_o,
  output logic            is_put_o,
  output logic            is_halt_o,
  output pc_sel_e         pc_sel_o
);

  always_comb begin
    acc_we_o  = 1'b0;
    alu_op_o  = ALU_PASS;
    is_put_o  = 1'b0;
    is_halt_o = 1'b0;
    pc_sel_o  = PC_STEP;
    case (opcode_i)
      OPC_HALT: begin
        is_halt_o = 1'b1;
        pc_sel_o  = PC_HOLD;
      end
      OPC_LDI: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_PASS;
      end
      OPC_ADD: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_ADD;
      end
      OPC_SUB: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_SUB;
      end
      OPC_AND: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_AND;
      end
      OPC_OR: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_OR;
      end
      OPC_XOR: begin
        acc_we_o = 1'b1;
        alu_op_o = ALU_XOR;
      end
      OPC_PUT: is_put_o = 1'b1;
      OPC_JMP: pc_sel_o = PC_LOAD;
      OPC_JZ:  pc_sel_o = PC_LOAD_IF_ZERO;
      default: pc_sel_o = PC_STEP;
    endcase
  end

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 12
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_x;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_x = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_nopad
      assign imm_x = imm_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (op_i)
      ALU_ADD: res_o = acc_i + imm_x;
      ALU_SUB: res_o = acc_i - imm_x;
      ALU_AND: res_o = acc_i & imm_x;
      ALU_OR:  res_o = acc_i | imm_x;
      ALU_XOR: res_o = acc_i ^ imm_x;
      default: res_o = imm_x;
    endcase
  end

  assign zero_o = (acc_i == '0);

endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_put_i,
  input  logic              is_halt_i,
  input  pc_sel_e           pc_sel_i,
  input  logic              acc_zero_i,
  input  logic [ADDR_W-1:0] param_i,
  output logic              exec_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o
);

  state_e            st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              pc_en, tgt_en;
  logic [ADDR_W-1:0] pc_inc;

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    tgt_d  = param_i;
    pc_en  = 1'b0;
    tgt_en = 1'b0;
    case (st_q)
      ST_BOOT:  st_d = ST_FETCH;
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC: begin
        pc_en = 1'b1;
        case (pc_sel_i)
          PC_LOAD:         pc_d = param_i;
          PC_LOAD_IF_ZERO: pc_d = acc_zero_i ? param_i : pc_inc;
          PC_HOLD:         pc_d = pc_q;
          default:         pc_d = pc_inc;
        endcase
        if (is_halt_i) begin
          st_d = ST_HALT;
        end else if (is_put_i) begin
          st_d   = ST_WRITE;
          tgt_en = 1'b1;
        end else begin
          st_d = ST_FETCH;
        end
      end
      ST_WRITE: st_d = ST_FETCH;
      default:  st_d = ST_HALT;
    endcase
  end

  always_comb begin
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = pc_q;
    case (st_q)
      ST_FETCH: mem_re_o = 1'b1;
      ST_EXEC: begin
        if (is_put_i && !is_halt_i) begin
          mem_re_o   = 1'b1;
          mem_addr_o = param_i;
        end
      end
      ST_WRITE: begin
        mem_we_o   = 1'b1;
        mem_addr_o = tgt_q;
      end
      default: mem_re_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_BOOT;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= tgt_d;
  end

  assign exec_o   = (st_q == ST_EXEC);
  assign pc_o     = pc_q;
  assign halted_o = (st_q == ST_HALT);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);

  localparam int PARAM_W = DATA_W - OP_W;

  logic                  core_rst_n;
  logic [OP_W-1:0]       opcode;
  logic [PARAM_W-1:0]    param;
  logic                  dec_acc_we;
  alu_op_e               dec_alu_op;
  logic                  dec_put;
  logic                  dec_halt;
  pc_sel_e               dec_pc_sel;
  logic [DATA_W-1:0]     alu_res;
  logic                  acc_zero;
  logic                  exec;
  logic                  acc_en;
  logic [DATA_W-1:0]     acc_q, acc_d;

  assign opcode = mem_rdata[DATA_W-1 -: OP_W];
  assign param  = mem_rdata[PARAM_W-1:0];

  acc_core_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  acc_core_decode u_dec (
    .opcode_i  (opcode),
    .acc_we_o  (dec_acc_we),
    .alu_op_o  (dec_alu_op),
    .is_put_o  (dec_put),
    .is_halt_o (dec_halt),
    .pc_sel_o  (dec_pc_sel)
  );

  acc_core_alu #(.DATA_W(DATA_W), .IMM_W(PARAM_W)) u_alu (
    .op_i   (dec_alu_op),
    .acc_i  (acc_q),
    .imm_i  (param),
    .res_o  (alu_res),
    .zero_o (acc_zero)
  );

  acc_core_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .is_put_i   (dec_put),
    .is_halt_i  (dec_halt),
    .pc_sel_i   (dec_pc_sel),
    .acc_zero_i (acc_zero),
    .param_i    (param[ADDR_W-1:0]),
    .exec_o     (exec),
    .mem_re_o   (mem_re),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .pc_o       (pc),
    .halted_o   (halted)
  );

  assign acc_en = exec & dec_acc_we;

  always_comb begin
    acc_d = acc_q;
    if (acc_en) acc_d = alu_res;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) acc_q <= '0;
    else             acc_q <= acc_d;
  end

  // Write cycle: mem_rdata holds the target word read during execute.
  assign mem_wdata = {mem_rdata[DATA_W-1 -: OP_W], acc_q[PARAM_W-1:0]};
  assign acc       = acc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_re,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (acc == '0 && pc == '0 && !halted && !mem_re && !mem_we));

  p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_exec_then_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_re) && !mem_re && !mem_we) |=> (mem_re || halted));

  p_write_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

  p_put_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(acc));

  p_write_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_re && mem_addr == pc));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_re && !mem_we));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .halted   (halted),
  .acc      (acc),
  .pc       (pc)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 4096;

  localparam int PH_BOOT  = 0;
  localparam int PH_FETCH = 1;
  localparam int PH_EXEC  = 2;
  localparam int PH_WRITE = 3;
  localparam int PH_HALT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #5 clk = ~clk;

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_re, mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              halted;
  logic [DATA_W-1:0] acc;
  logic [ADDR_W-1:0] pc;

  acc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .acc(acc), .pc(pc)
  );

  int vectors = 0;
  int fails   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench memory: synchronous, one-cycle read latency
  logic [DATA_W-1:0] mem [DEPTH];
  logic              ld_en = 1'b0, clr = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // Reference model
  logic [DATA_W-1:0] ref_mem [DEPTH];
  int                m_cnt = 0;
  int                m_phase = PH_BOOT;
  logic [DATA_W-1:0] m_acc = '0;
  logic [ADDR_W-1:0] m_pc = '0;
  logic [ADDR_W-1:0] m_tgt = '0;
  string             m_tag = "R1";
  logic              armed = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) m_cnt <= 0;
    else if (m_cnt < 3) m_cnt <= m_cnt + 1;
  end

  always @(negedge clk) begin
    logic [DATA_W-1:0] ins;
    logic [3:0]        op;
    logic [11:0]       prm;
    logic              e_re, e_we;
    logic [ADDR_W-1:0] e_addr;
    logic [DATA_W-1:0] e_wd;
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    end else if (ld_en) begin
      ref_mem[ld_addr] = ld_data;
    end
    if (armed && !rst_n) begin
      m_phase = PH_BOOT; m_acc = '0; m_pc = '0; m_tag = "R1";
      chk("R1 acc in reset", acc, 0);
      chk("R1 pc in reset", pc, 0);
      chk("R1 halted in reset", halted, 0);
      chk("R1 access in reset", {mem_re, mem_we}, 0);
    end else if (armed) begin
      ins = ref_mem[m_pc]; op = ins[15:12]; prm = ins[11:0];
      e_re = 1'b0; e_we = 1'b0; e_addr = '0; e_wd = '0;
      case (m_phase)
        PH_FETCH: begin e_re = 1'b1; e_addr = m_pc; end
        PH_EXEC:  if (op == 4'h7) begin e_re = 1'b1; e_addr = prm; end
        PH_WRITE: begin
          e_we = 1'b1; e_addr = m_tgt;
          e_wd = {ref_mem[m_tgt][15:12], m_acc[11:0]};
        end
        default: ;
      endcase
      chk({m_tag, " acc"}, acc, m_acc);
      chk({m_tag, " pc"}, pc, m_pc);
      chk("R9 halted", halted, (m_phase == PH_HALT));
      chk("R3 mem_re", mem_re, e_re);
      chk("R7 mem_we", mem_we, e_we);
      if (e_re || e_we) chk("R3 mem_addr", mem_addr, e_addr);
      if (e_we) chk("R7 mem_wdata", mem_wdata, e_wd);
      // advance one clock
      case (m_phase)
        PH_BOOT:  if (m_cnt >= 2) m_phase = PH_FETCH;
        PH_FETCH: m_phase = PH_EXEC;
        PH_EXEC: begin
          m_phase = PH_FETCH;
          case (op)
            4'h0: begin m_phase = PH_HALT; m_tag = "R9"; end
            4'h1: begin m_acc = {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h2: begin m_acc = m_acc + {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h3: begin m_acc = m_acc - {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h4: begin m_acc = m_acc & {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h5: begin m_acc = m_acc | {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h6: begin m_acc = m_acc ^ {4'h0, prm}; m_pc = m_pc + 1; m_tag = "R4"; end
            4'h7: begin m_tgt = prm; m_pc = m_pc + 1; m_phase = PH_WRITE; m_tag = "R7"; end
            4'h8: begin m_pc = prm; m_tag = "R6"; end
            4'h9: begin m_pc = (m_acc == 0) ? prm : m_pc + 1; m_tag = "R6"; end
            default: begin m_pc = m_pc + 1; m_tag = "R10"; end
          endcase
        end
        PH_WRITE: begin
          ref_mem[m_tgt] = {ref_mem[m_tgt][15:12], m_acc[11:0]};
          m_phase = PH_FETCH; m_tag = "R8";
        end
        default: m_phase = PH_HALT;
      endcase
    end
  end

  function automatic logic [15:0] w(input logic [3:0] op, input logic [11:0] p);
    return {op, p};
  endfunction

  task automatic put_word(input logic [11:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    @(posedge clk); #1; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
  endtask

  task automatic release_rst();
    @(posedge clk); #1; rst_n = 1'b1;
  endtask

  task automatic enter_rst();
    @(posedge clk); #1; rst_n = 1'b0;
  endtask

  task automatic wait_halt(input string tag);
    int n;
    n = 0;
    while (!halted && n < 3000) begin @(posedge clk); n++; end
    if (!halted) begin
      fails++; vectors++;
      $display("FAIL %s watchdog: halted=0 expected=1", tag);
    end
    repeat (6) @(posedge clk);
    #4;
  endtask

  initial begin
    #2 rst_n = 1'b0;
    armed = 1'b1;

    // Program 1: arithmetic, jumps, NOP, PUT into a JZ word
    clear_mem();
    put_word(12'h000, w(4'h1, 12'h0F0));
    put_word(12'h001, w(4'h2, 12'h123));
    put_word(12'h002, w(4'h3, 12'h014));
    put_word(12'h003, w(4'h4, 12'h0F3));
    put_word(12'h004, w(4'h5, 12'h800));
    put_word(12'h005, w(4'h6, 12'h0FF));
    put_word(12'h006, w(4'h3, 12'hFFF));
    put_word(12'h007, w(4'h7, 12'h020));
    put_word(12'h008, w(4'hB, 12'h123));
    put_word(12'h009, w(4'h9, 12'h00F));
    put_word(12'h00A, w(4'h1, 12'h000));
    put_word(12'h00B, w(4'h9, 12'h00E));
    put_word(12'h00C, w(4'h1, 12'h555));
    put_word(12'h00D, w(4'h0, 12'h000));
    put_word(12'h00E, w(4'h8, 12'h011));
    put_word(12'h00F, w(4'h1, 12'h666));
    put_word(12'h010, w(4'h0, 12'h000));
    put_word(12'h011, w(4'h2, 12'h00A));
    put_word(12'h012, w(4'h0, 12'h000));
    put_word(12'h020, w(4'h9, 12'h123));
    #3;
    chk("R1 acc before release", acc, 0);
    chk("R1 no read before release", mem_re, 0);
    release_rst();
    // R1: quiet for three falling edges, then fetch of address 0
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R1 boot quiet", {mem_re, mem_we}, 0);
    end
    @(negedge clk); #1;
    chk("R1 first fetch", {mem_re, 4'h0, mem_addr}, {1'b1, 4'h0, 12'h000});
    wait_halt("R9");
    chk("R6 final acc prog1", acc, 16'h000A);
    chk("R9 pc holds halt addr", pc, 12'h012);
    chk("R2 PUT keeps opcode", mem[12'h020], 16'h980D);
    enter_rst();

    // Program 2: PUT into PUT, rewrite of the next instruction
    clear_mem();
    put_word(12'h000, w(4'h1, 12'h040));
    put_word(12'h001, w(4'h7, 12'h003));
    put_word(12'h002, w(4'h1, 12'h5A5));
    put_word(12'h003, w(4'h7, 12'h000));
    put_word(12'h004, w(4'h7, 12'h005));
    put_word(12'h005, w(4'h2, 12'h001));
    put_word(12'h006, w(4'h8, 12'h040));
    put_word(12'h040, w(4'h1, 12'h000));
    put_word(12'h041, w(4'h2, 12'h001));
    put_word(12'h042, w(4'h0, 12'h000));
    release_rst();
    wait_halt("R8");
    chk("R8 final acc prog2", acc, 16'h05A6);
    chk("R8 PUT operand rewritten", mem[12'h003], 16'h7040);
    chk("R8 indirect target", mem[12'h040], 16'h15A5);
    chk("R8 next word rewritten", mem[12'h005], 16'h25A5);
    enter_rst();

    // Program 3: countdown loop held in an operand field
    clear_mem();
    put_word(12'h000, w(4'h1, 12'h003));
    put_word(12'h001, w(4'h7, 12'h020));
    put_word(12'h002, w(4'h8, 12'h020));
    put_word(12'h020, w(4'h1, 12'h000));
    put_word(12'h021, w(4'h3, 12'h001));
    put_word(12'h022, w(4'h9, 12'h030));
    put_word(12'h023, w(4'h7, 12'h020));
    put_word(12'h024, w(4'h8, 12'h020));
    put_word(12'h030, w(4'h1, 12'hABC));
    put_word(12'h031, w(4'h0, 12'h000));
    release_rst();
    wait_halt("R6");
    chk("R6 loop exit acc", acc, 16'h0ABC);
    chk("R7 counter word", mem[12'h020], 16'h1001);
    // R11: rerun and reset in the middle
    enter_rst();
    release_rst();
    repeat (14) @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R11 acc cleared", acc, 0);
    chk("R11 pc cleared", pc, 0);
    chk("R11 no access", {mem_re, mem_we}, 0);
    release_rst();
    wait_halt("R11");
    chk("R11 restart result", acc, 16'h0ABC);
    enter_rst();

    // Program 4: pc wrap and undefined opcode
    clear_mem();
    put_word(12'h000, w(4'h9, 12'h010));
    put_word(12'h010, w(4'h1, 12'h001));
    put_word(12'h011, w(4'hF, 12'h000));
    put_word(12'h012, w(4'h8, 12'hFFF));
    put_word(12'hFFF, w(4'h2, 12'h005));
    release_rst();
    wait_halt("R5");
    chk("R5 wrap final pc", pc, 12'h001);
    chk("R10 final acc", acc, 16'h0006);
    enter_rst();
    repeat (3) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule